// File: doc/BRIEF.md
# UART Register and Interrupt Control Bank

This block is the register-side control plane of a simple asynchronous serial port. It connects to a 32-bit register bus and converts the bus accesses into the signals that the receive and transmit datapaths need. A write to the command word produces strobes that last one clock. These strobes reset, enable or disable each direction, clear the sticky error flags, or request a clear. The block holds the line-mode, baud-divisor and character-match configuration and drives those fields out on ports. It exchanges characters with the datapaths through a transmit push strobe and a receive pop strobe.

Seven status sources feed the block. Receiver ready, transmitter ready and transmitter empty are live levels from the datapaths. Overrun, framing error, parity error and character match arrive as event pulses, and the block latches each one until a status-reset command clears it. A seven-bit interrupt mask selects which sources reach the single interrupt line. Software cannot write the mask directly: it can only set bits through one register and clear bits through another. A keyed lock protects the three configuration registers from stray writes.

Top module: `uart_regbank`

## Requirements
- R1: A write to byte offset 0x00 raises, one cycle later and for exactly one cycle, a strobe for each set bit: bit 2 receiver reset, bit 3 transmitter reset, bit 4 receiver enable, bit 5 receiver disable, bit 6 transmitter enable, bit 7 transmitter disable, bit 8 status reset, bit 12 clear request.
- R2: When one command write sets both the enable and the disable bit of the same direction, only the disable strobe is raised.
- R3: Interrupt sources sit at bits 0 receiver ready, 1 transmitter ready, 5 overrun, 6 framing, 7 parity, 9 transmitter empty and 15 match. Each 1 written at offset 0x08 sets the matching mask bit, and each 1 written at offset 0x0C clears it. The mask reads back at offset 0x10. Writes to 0x10 have no effect, and bits that are not sources never become set.
- R4: The status word at offset 0x14 uses the R3 bit positions. Bits 0, 1 and 9 follow the live inputs. Bits 5, 6, 7 and 15 are set by their event pulses and stay set until a status-reset command clears them.
- R5: The interrupt output is high exactly when at least one status bit is set while its mask bit is set.
- R6: A write at offset 0xE4 takes effect only when bits 31:8 hold 0x554152. In that case bit 0 becomes the lock state. A read at 0xE4 returns only the lock state in bit 0, with the key field reading as zero.
- R7: While the lock is on, writes to the mode (0x04), baud divisor (0x20) and match (0x24) registers are ignored. Command, interrupt-set, interrupt-clear and transmit writes still take effect.
- R8: Configuration registers reset to zero and keep only their defined fields. Mode keeps bit 4 filter, bits 11:9 parity, bit 12 clock source and bits 15:14 channel mode. The divisor keeps bits 15:0. Match keeps bits 7:0 first value, bit 12 start mode, bit 14 parity compare and bits 23:16 second value. Each register drives its fields out and reads back masked.
- R9: Reads of the write-only offsets 0x00, 0x08, 0x0C and 0x1C, and of any unmapped offset, return zero.
- R10: A read at 0x18 returns the receive character in bits 7:0 and raises the pop strobe for one cycle. A write at 0x1C raises the push strobe for one cycle, with write bits 7:0 on the transmit character port.
- R11: After reset all strobes and the interrupt are low, the mask is empty and the lock is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| rx_ready_i | input | 1 | Receiver holds a character (level) |
| tx_ready_i | input | 1 | Transmitter can accept a character (level) |
| tx_empty_i | input | 1 | Transmitter fully idle (level) |
| err_ovr_i | input | 1 | Overrun event pulse |
| err_frm_i | input | 1 | Framing error event pulse |
| err_par_i | input | 1 | Parity error event pulse |
| match_i | input | 1 | Character match event pulse |
| rx_char_i | input | 8 | Current received character |
| rx_rst_o | output | 1 | Receiver reset strobe |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| rx_en_o | output | 1 | Receiver enable strobe |
| rx_dis_o | output | 1 | Receiver disable strobe |
| tx_en_o | output | 1 | Transmitter enable strobe |
| tx_dis_o | output | 1 | Transmitter disable strobe |
| sta_rst_o | output | 1 | Status reset strobe |
| req_clr_o | output | 1 | Clear request strobe |
| rx_pop_o | output | 1 | Receive character consumed strobe |
| tx_push_o | output | 1 | Transmit character strobe |
| tx_char_o | output | 8 | Character to transmit |
| filter_o | output | 1 | Receive line filter enable |
| parity_o | output | 3 | Parity type code |
| clk_src_o | output | 1 | Baud clock source select |
| chan_mode_o | output | 2 | Channel mode code |
| baud_div_o | output | 16 | Baud clock divisor |
| match_lo_o | output | 8 | First match value |
| match_hi_o | output | 8 | Second match value |
| match_start_o | output | 1 | Match gates reception start |
| match_par_o | output | 1 | Compare parity during match |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the interaction between the lock and the registers around it. A register must be shown to ignore a write only while the lock is on, and the lock itself must ignore a write that carries a bad key. The stimulus first writes a wrong key with bit 0 set and shows that the divisor still accepts a change. It then locks with the correct key and confirms by read-back that mode and divisor writes leave the earlier values, while interrupt-set and command writes still act. Finally it unlocks and shows that divisor writes land again. Sticky flags get similar treatment: the stimulus injects event pulses with the live inputs held high, so that a status reset must clear the latched bits and leave the live bits in place.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    // byte offsets of the register words
    localparam logic [7:0] OFF_CMD    = 8'h00;
    localparam logic [7:0] OFF_MODE   = 8'h04;
    localparam logic [7:0] OFF_ISET   = 8'h08;
    localparam logic [7:0] OFF_ICLR   = 8'h0C;
    localparam logic [7:0] OFF_IMASK  = 8'h10;
    localparam logic [7:0] OFF_STAT   = 8'h14;
    localparam logic [7:0] OFF_RXCH   = 8'h18;
    localparam logic [7:0] OFF_TXCH   = 8'h1C;
    localparam logic [7:0] OFF_BAUD   = 8'h20;
    localparam logic [7:0] OFF_MATCH  = 8'h24;
    localparam logic [7:0] OFF_LOCK   = 8'hE4;

    localparam logic [23:0] LOCK_KEY  = 24'h554152;

    // source positions shared by set, clear, mask and status words
    localparam int SB_RXRDY = 0;
    localparam int SB_TXRDY = 1;
    localparam int SB_OVR   = 5;
    localparam int SB_FRM   = 6;
    localparam int SB_PAR   = 7;
    localparam int SB_TXEMP = 9;
    localparam int SB_MATCH = 15;
    localparam logic [15:0] SRC_BITS = 16'h82E3;

    localparam logic [31:0] MODE_BITS  = 32'h0000_DE10;
    localparam logic [31:0] BAUD_BITS  = 32'h0000_FFFF;
    localparam logic [31:0] MATCH_BITS = 32'h00FF_50FF;

    typedef struct packed {
        logic rx_rst;
        logic tx_rst;
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic sta_rst;
        logic req_clr;
    } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_regbank_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_hit,
    // {req_clr, sta_rst, tx_off, tx_on, rx_off, rx_on, tx_rst, rx_rst}
    input  logic [7:0] cmd_bits,
    output cmd_t       cmd_o
);

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = '0;
        if (cmd_hit) begin
            cmd_d.rx_rst  = cmd_bits[0];
            cmd_d.tx_rst  = cmd_bits[1];
            // a disable request overrides an enable in the same write
            cmd_d.rx_on   = cmd_bits[2] & ~cmd_bits[3];
            cmd_d.rx_off  = cmd_bits[3];
            cmd_d.tx_on   = cmd_bits[4] & ~cmd_bits[5];
            cmd_d.tx_off  = cmd_bits[5];
            cmd_d.sta_rst = cmd_bits[6];
            cmd_d.req_clr = cmd_bits[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_o = cmd_q;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_regbank_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_hit,
    input  logic             clr_hit,
    input  logic [SRC_W-1:0] wbits,
    input  logic             sta_clear,
    input  logic             rx_ready_i,
    input  logic             tx_ready_i,
    input  logic             tx_empty_i,
    input  logic             err_ovr_i,
    input  logic             err_frm_i,
    input  logic             err_par_i,
    input  logic             match_i,
    output logic [SRC_W-1:0] status_o,
    output logic [SRC_W-1:0] mask_o,
    output logic             irq_o
);

    localparam logic [SRC_W-1:0] SRC = SRC_W'(SRC_BITS);

    typedef struct packed {
        logic [SRC_W-1:0] mask;
        logic             ovr;
        logic             frm;
        logic             par;
        logic             mat;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [SRC_W-1:0] status;

    always_comb begin
        st_d = st_q;
        if (set_hit) st_d.mask = st_d.mask | (wbits & SRC);
        if (clr_hit) st_d.mask = st_d.mask & ~wbits;
        // clear first, then a same-cycle event still lands
        if (sta_clear) begin
            st_d.ovr = 1'b0;
            st_d.frm = 1'b0;
            st_d.par = 1'b0;
            st_d.mat = 1'b0;
        end
        if (err_ovr_i) st_d.ovr = 1'b1;
        if (err_frm_i) st_d.frm = 1'b1;
        if (err_par_i) st_d.par = 1'b1;
        if (match_i)   st_d.mat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status           = '0;
        status[SB_RXRDY] = rx_ready_i;
        status[SB_TXRDY] = tx_ready_i;
        status[SB_OVR]   = st_q.ovr;
        status[SB_FRM]   = st_q.frm;
        status[SB_PAR]   = st_q.par;
        status[SB_TXEMP] = tx_empty_i;
        status[SB_MATCH] = st_q.mat;
    end

    assign status_o = status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(status & st_q.mask);

endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
    import uart_regbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_hit,
    input  logic          baud_hit,
    input  logic          match_hit,
    input  logic          lock_hit,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] baud_o,
    output logic [DW-1:0] match_o,
    output logic          locked_o
);

    localparam int KEY_LSB = 8;

    typedef struct packed {
        logic [DW-1:0] mode;
        logic [DW-1:0] baud;
        logic [DW-1:0] match;
        logic          locked;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       key_ok;

    assign key_ok = (wdata[DW-1:KEY_LSB] == LOCK_KEY);

    always_comb begin
        st_d = st_q;
        if (!st_q.locked) begin
            if (mode_hit)  st_d.mode  = wdata & DW'(MODE_BITS);
            if (baud_hit)  st_d.baud  = wdata & DW'(BAUD_BITS);
            if (match_hit) st_d.match = wdata & DW'(MATCH_BITS);
        end
        if (lock_hit && key_ok) st_d.locked = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign baud_o   = st_q.baud;
    assign match_o  = st_q.match;
    assign locked_o = st_q.locked;

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_ready_i,
    input  logic              tx_ready_i,
    input  logic              tx_empty_i,
    input  logic              err_ovr_i,
    input  logic              err_frm_i,
    input  logic              err_par_i,
    input  logic              match_i,
    input  logic [7:0]        rx_char_i,
    output logic              rx_rst_o,
    output logic              tx_rst_o,
    output logic              rx_en_o,
    output logic              rx_dis_o,
    output logic              tx_en_o,
    output logic              tx_dis_o,
    output logic              sta_rst_o,
    output logic              req_clr_o,
    output logic              rx_pop_o,
    output logic              tx_push_o,
    output logic [7:0]        tx_char_o,
    output logic              filter_o,
    output logic [2:0]        parity_o,
    output logic              clk_src_o,
    output logic [1:0]        chan_mode_o,
    output logic [15:0]       baud_div_o,
    output logic [7:0]        match_lo_o,
    output logic [7:0]        match_hi_o,
    output logic              match_start_o,
    output logic              match_par_o,
    output logic              irq_o
);

    localparam int SRC_W = 16;

    logic wr_cmd, wr_mode, wr_iset, wr_iclr, wr_txch, wr_baud, wr_match, wr_lock;
    logic sta_clear;
    cmd_t cmd;
    logic [SRC_W-1:0]  status_w, mask_w;
    logic [DATA_W-1:0] mode_w, baud_w, match_w;
    logic              lock_w;

    assign wr_cmd   = bus_wr && (bus_addr == OFF_CMD);
    assign wr_mode  = bus_wr && (bus_addr == OFF_MODE);
    assign wr_iset  = bus_wr && (bus_addr == OFF_ISET);
    assign wr_iclr  = bus_wr && (bus_addr == OFF_ICLR);
    assign wr_txch  = bus_wr && (bus_addr == OFF_TXCH);
    assign wr_baud  = bus_wr && (bus_addr == OFF_BAUD);
    assign wr_match = bus_wr && (bus_addr == OFF_MATCH);
    assign wr_lock  = bus_wr && (bus_addr == OFF_LOCK);
    assign sta_clear = wr_cmd && bus_wdata[8];

    uart_cmd_decode u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_hit  (wr_cmd),
        .cmd_bits ({bus_wdata[12], bus_wdata[8:2]}),
        .cmd_o    (cmd)
    );

    uart_irq_ctrl #(.SRC_W(SRC_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_hit    (wr_iset),
        .clr_hit    (wr_iclr),
        .wbits      (bus_wdata[SRC_W-1:0]),
        .sta_clear  (sta_clear),
        .rx_ready_i (rx_ready_i),
        .tx_ready_i (tx_ready_i),
        .tx_empty_i (tx_empty_i),
        .err_ovr_i  (err_ovr_i),
        .err_frm_i  (err_frm_i),
        .err_par_i  (err_par_i),
        .match_i    (match_i),
        .status_o   (status_w),
        .mask_o     (mask_w),
        .irq_o      (irq_o)
    );

    uart_cfg_regs #(.DW(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_hit  (wr_mode),
        .baud_hit  (wr_baud),
        .match_hit (wr_match),
        .lock_hit  (wr_lock),
        .wdata     (bus_wdata),
        .mode_o    (mode_w),
        .baud_o    (baud_w),
        .match_o   (match_w),
        .locked_o  (lock_w)
    );

    // bus-side registers: read data, pop and push strobes
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              pop;
        logic              push;
        logic [7:0]        txch;
    } bus_state_t;

    bus_state_t bs_d, bs_q;

    always_comb begin
        bs_d       = bs_q;
        bs_d.rdata = '0;
        bs_d.pop   = 1'b0;
        bs_d.push  = 1'b0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFF_MODE:  bs_d.rdata = mode_w;
                OFF_IMASK: bs_d.rdata = DATA_W'(mask_w);
                OFF_STAT:  bs_d.rdata = DATA_W'(status_w);
                OFF_RXCH: begin
                    bs_d.rdata = DATA_W'(rx_char_i);
                    bs_d.pop   = 1'b1;
                end
                OFF_BAUD:  bs_d.rdata = baud_w;
                OFF_MATCH: bs_d.rdata = match_w;
                OFF_LOCK:  bs_d.rdata = DATA_W'(lock_w);
                default:   bs_d.rdata = '0;
            endcase
        end
        if (wr_txch) begin
            bs_d.push = 1'b1;
            bs_d.txch = bus_wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

    assign bus_rdata = bs_q.rdata;
    assign rx_pop_o  = bs_q.pop;
    assign tx_push_o = bs_q.push;
    assign tx_char_o = bs_q.txch;

    assign rx_rst_o  = cmd.rx_rst;
    assign tx_rst_o  = cmd.tx_rst;
    assign rx_en_o   = cmd.rx_on;
    assign rx_dis_o  = cmd.rx_off;
    assign tx_en_o   = cmd.tx_on;
    assign tx_dis_o  = cmd.tx_off;
    assign sta_rst_o = cmd.sta_rst;
    assign req_clr_o = cmd.req_clr;

    assign filter_o      = mode_w[4];
    assign parity_o      = mode_w[11:9];
    assign clk_src_o     = mode_w[12];
    assign chan_mode_o   = mode_w[15:14];
    assign baud_div_o    = baud_w[15:0];
    assign match_lo_o    = match_w[7:0];
    assign match_start_o = match_w[12];
    assign match_par_o   = match_w[14];
    assign match_hi_o    = match_w[23:16];

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
    import uart_regbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rx_en_o,
    input logic              rx_dis_o,
    input logic              tx_en_o,
    input logic              tx_dis_o,
    input logic              rx_pop_o,
    input logic              tx_push_o,
    input logic [15:0]       baud_div_o,
    input logic              err_ovr_i,
    input logic [15:0]       status,
    input logic [15:0]       mask,
    input logic              locked
);

    a_r1_rx_en_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en_o |-> $past(bus_wr && bus_addr == OFF_CMD && bus_wdata[4]));

    a_r2_rx_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en_o && rx_dis_o));

    a_r2_tx_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en_o && tx_dis_o));

    a_r3_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_ISET && bus_wdata[0]) |=> mask[0]);

    a_r4_ovr_latched: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovr_i |=> status[5]);

    a_r6_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(locked) |-> $past(bus_wr && bus_addr == OFF_LOCK
                                   && bus_wdata[31:8] == LOCK_KEY));

    a_r7_baud_held: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_wr && bus_addr == OFF_BAUD) |=> $stable(baud_div_o));

    a_r10_push_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push_o |-> $past(bus_wr && bus_addr == OFF_TXCH));

    a_r10_pop_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop_o |-> $past(bus_rd && bus_addr == OFF_RXCH));

endmodule

bind uart_regbank uart_regbank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .rx_en_o    (rx_en_o),
    .rx_dis_o   (rx_dis_o),
    .tx_en_o    (tx_en_o),
    .tx_dis_o   (tx_dis_o),
    .rx_pop_o   (rx_pop_o),
    .tx_push_o  (tx_push_o),
    .baud_div_o (baud_div_o),
    .err_ovr_i  (err_ovr_i),
    .status     (status_w),
    .mask       (mask_w),
    .locked     (lock_w)
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_ready_i = 0, tx_ready_i = 0, tx_empty_i = 0;
    logic        err_ovr_i = 0, err_frm_i = 0, err_par_i = 0, match_i = 0;
    logic [7:0]  rx_char_i = '0;
    logic        rx_rst_o, tx_rst_o, rx_en_o, rx_dis_o, tx_en_o, tx_dis_o;
    logic        sta_rst_o, req_clr_o, rx_pop_o, tx_push_o;
    logic [7:0]  tx_char_o;
    logic        filter_o, clk_src_o, match_start_o, match_par_o, irq_o;
    logic [2:0]  parity_o;
    logic [1:0]  chan_mode_o;
    logic [15:0] baud_div_o;
    logic [7:0]  match_lo_o, match_hi_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_regbank u_uart_regbank (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] strobes();
        return {rx_rst_o, tx_rst_o, rx_en_o, rx_dis_o, tx_en_o, tx_dis_o, sta_rst_o, req_clr_o};
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        check("R11 strobes", 32'(strobes()), 0);
        check("R11 irq", 32'(irq_o), 0);
        bus_read(8'h10, v); check("R11 mask", v, 0);
        bus_read(8'hE4, v); check("R11 lock", v, 0);
        bus_read(8'h20, v); check("R8 baud reset", v, 0);
    endtask

    task automatic t_commands();
        // order: rx_rst tx_rst rx_en rx_dis tx_en tx_dis sta_rst req_clr
        bus_write(8'h00, 32'h0000_111C);
        check("R1 strobes 0x111C", 32'(strobes()), 32'b1110_0011);
        @(negedge clk);
        check("R1 strobe one cycle", 32'(strobes()), 0);
        bus_write(8'h00, 32'h0000_0040);
        check("R1 tx enable", 32'(strobes()), 32'b0000_1000);
        bus_write(8'h00, 32'h0000_0030);
        check("R2 rx disable wins", 32'(strobes()), 32'b0001_0000);
        bus_write(8'h00, 32'h0000_00C0);
        check("R2 tx disable wins", 32'(strobes()), 32'b0000_0100);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        bus_write(8'h08, 32'h0000_82E3);
        bus_read(8'h10, v); check("R3 set all", v, 32'h82E3);
        bus_write(8'h0C, 32'h0000_0201);
        bus_read(8'h10, v); check("R3 clear two", v, 32'h80E2);
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, v); check("R3 mask write ignored", v, 32'h80E2);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'h0000_FFFF);
        bus_read(8'h10, v); check("R3 non-source bits", v, 32'h82E3);
        bus_write(8'h0C, 32'h0000_FFFF);
        bus_read(8'h10, v); check("R3 clear all", v, 0);
    endtask

    task automatic t_status();
        logic [31:0] v;
        @(negedge clk); err_ovr_i = 1; err_frm_i = 1;
        @(negedge clk); err_ovr_i = 0; err_frm_i = 0;
        @(negedge clk);
        bus_read(8'h14, v); check("R4 sticky ovr frm", v, 32'h0060);
        rx_ready_i = 1; tx_ready_i = 1; tx_empty_i = 1;
        bus_read(8'h14, v); check("R4 live bits", v, 32'h0263);
        bus_write(8'h00, 32'h0000_0100);
        bus_read(8'h14, v); check("R4 status reset", v, 32'h0203);
        @(negedge clk); err_par_i = 1; match_i = 1;
        @(negedge clk); err_par_i = 0; match_i = 0;
        rx_ready_i = 0; tx_ready_i = 0; tx_empty_i = 0;
        bus_read(8'h14, v); check("R4 parity match", v, 32'h8080);
        bus_write(8'h00, 32'h0000_0100);
        bus_read(8'h14, v); check("R4 cleared again", v, 0);
    endtask

    task automatic t_irq();
        bus_write(8'h08, 32'h0000_0001);
        #1 check("R5 masked idle", 32'(irq_o), 0);
        rx_ready_i = 1;
        #1 check("R5 rx ready", 32'(irq_o), 1);
        rx_ready_i = 0; tx_ready_i = 1;
        #1 check("R5 unmasked source", 32'(irq_o), 0);
        tx_ready_i = 0;
        bus_write(8'h08, 32'h0000_0080);
        @(negedge clk); err_par_i = 1;
        @(negedge clk); err_par_i = 0;
        check("R5 parity latched", 32'(irq_o), 1);
        bus_write(8'h0C, 32'h0000_0080);
        check("R5 masked off", 32'(irq_o), 0);
        bus_write(8'h00, 32'h0000_0100);
        bus_write(8'h0C, 32'h0000_FFFF);
    endtask

    task automatic t_config_lock();
        logic [31:0] v;
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, v); check("R8 mode fields", v, 32'h0000_DE10);
        check("R8 mode ports", {27'b0, filter_o, parity_o, chan_mode_o}, 32'h3F);
        bus_write(8'h20, 32'h1234_ABCD);
        bus_read(8'h20, v); check("R8 baud", v, 32'h0000_ABCD);
        bus_write(8'h24, 32'hFFFF_FFFF);
        bus_read(8'h24, v); check("R8 match fields", v, 32'h00FF_50FF);
        check("R8 match ports", {14'b0, match_hi_o, match_lo_o, match_start_o, match_par_o},
              32'h3FFFF);
        bus_write(8'hE4, 32'h1234_5601);
        bus_read(8'hE4, v); check("R6 bad key ignored", v, 0);
        bus_write(8'h20, 32'h0000_1111);
        bus_read(8'h20, v); check("R6 still unlocked", v, 32'h1111);
        bus_write(8'hE4, 32'h5541_5201);
        bus_read(8'hE4, v); check("R6 lock on readback", v, 32'h1);
        bus_write(8'h20, 32'h0000_2222);
        bus_read(8'h20, v); check("R7 baud held", v, 32'h1111);
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, v); check("R7 mode held", v, 32'h0000_DE10);
        bus_write(8'h24, 32'h0);
        bus_read(8'h24, v); check("R7 match held", v, 32'h00FF_50FF);
        bus_write(8'h08, 32'h0000_0002);
        bus_read(8'h10, v); check("R7 mask still writable", v, 32'h2);
        bus_write(8'h00, 32'h0000_0004);
        check("R7 command still works", 32'(strobes()), 32'b1000_0000);
        bus_write(8'hE4, 32'h5541_5200);
        bus_read(8'hE4, v); check("R6 unlock", v, 0);
        bus_write(8'h20, 32'h0000_3333);
        bus_read(8'h20, v); check("R7 writable again", v, 32'h3333);
        bus_write(8'h0C, 32'h0000_FFFF);
    endtask

    task automatic t_empty_reads();
        logic [31:0] v;
        bus_write(8'h00, 32'h0); // lets the reads follow a quiet bus
        bus_read(8'h00, v); check("R9 command read", v, 0);
        bus_read(8'h08, v); check("R9 set read", v, 0);
        bus_read(8'h0C, v); check("R9 clear read", v, 0);
        bus_read(8'h1C, v); check("R9 transmit read", v, 0);
        bus_read(8'h28, v); check("R9 unmapped 0x28", v, 0);
        bus_read(8'hFC, v); check("R9 unmapped 0xFC", v, 0);
    endtask

    task automatic t_chars();
        logic [31:0] v;
        rx_char_i = 8'hA5;
        bus_read(8'h18, v);
        check("R10 rx char", v, 32'hA5);
        check("R10 pop strobe", 32'(rx_pop_o), 1);
        @(negedge clk);
        check("R10 pop one cycle", 32'(rx_pop_o), 0);
        bus_write(8'h1C, 32'h0000_01C3);
        check("R10 push strobe", 32'(tx_push_o), 1);
        check("R10 tx char", 32'(tx_char_o), 32'hC3);
        @(negedge clk);
        check("R10 push one cycle", 32'(tx_push_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_commands();
        t_mask();
        t_status();
        t_irq();
        t_config_lock();
        t_empty_reads();
        t_chars();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule